// File: doc/BRIEF.md
# Mesh Array Processing Cell

This block is a single cell of a two-dimensional bit-plane processing array. Each cell holds ten one-bit state flops: a transfer flop, an auxiliary flop and eight ordering flops. Every cell of the array receives the same 40-bit micro-instruction in the same cycle. The control lines are not decoded: each instruction bit drives one gate, one select or one complement directly.

In each cycle the cell drives its transmit line, which is the AND of the flops picked by the read group and can be inverted. It also forms an incident bit, which is the OR of the open input gates over its eight neighbours and its own transmit line. The incident bit can be inverted. An input gate can be made conditional, so that it opens only when the flop with the same number holds 1. The incident bit is then written into the flops picked by the load group. When a bubble operation is requested, the incident bit instead enables a bubble pass over the eight ordering flops. That pass repeats its swap step up to seven times within the cycle.

The array can be wired with eight neighbours on a square grid or six neighbours on a rhombic grid, and an input selects between the two. The whole state is brought out as a ten-bit plane port.

Top module: `grid_pe`

## Requirements
- R1: The instruction layout is as follows. Bits [39:30] are the flow group, [29:20] the read group, [19:10] the gate group and [9:0] the load group. The flow bits are: 39 inverts the transmit line, 38 inverts the incident bit, 37 enables the gates, 36 is reserved and has no effect, 35 requests a bubble, 34 moves ones up, 33 moves ones down, and [32:30] give the step count. In the read and load groups, bit j selects state flop j. Flop 0 is the auxiliary flop, flops 1 to 8 are the ordering flops and flop 9 is the transfer flop. These map to `flops_o[j]`.
- R2: `out_o` is the AND of the flops selected by the read group, XOR bit 39. An empty read group gives an AND of 1.
- R3: `incident_o` is the OR over the open gates, XOR bit 38. Gate 0 carries the cell's own `out_o`. Gate k (1..8) carries `nbr_i[k-1]`. Gate j is open when gate-group bit j is 1 and bit 37 is 1. When bit 37 is 0, no gate is open.
- R4: When gate-group bit 9 is 1, gate j is open only if state flop j held 1 before the instruction.
- R5: When `rhombic_i` is 1, gates 7 and 8 stay closed whatever their bits say.
- R6: When bit 35 is 0 and the read and load groups are disjoint, every flop selected by the load group takes the incident bit on the clock edge. Every other flop keeps its value.
- R7: When bit 35 is 0 and the read and load groups share any bit, no flop changes and `err_o` is 1 in the next cycle. Otherwise `err_o` is 0 after the edge.
- R8: When bit 35 is 1, the load group is ignored and flops 0 and 9 keep their values. If the incident bit is 0, nothing changes. If the incident bit is 1, the ordering flops take [32:30] swap steps. With bit 33 set and bit 34 clear, each step swaps every pair with 1 in flop k and 0 in flop k+1. With bit 34 set and bit 33 clear, each step swaps every pair with 0 in flop k and 1 in flop k+1. With both bits or neither bit set, the ordering flops do not move.
- R9: A bubble with step count 7 fully orders the eight ordering flops in its direction. A step count of 0 leaves them unchanged.
- R10: While `rst_ni` is low, all flops and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 40 | Broadcast micro-instruction |
| rhombic_i | input | 1 | 1 selects six-neighbour rhombic wiring |
| nbr_i | input | 8 | Transmit lines of neighbours 1..8 (bit k-1 is neighbour k) |
| out_o | output | 1 | Transmit line of this cell |
| incident_o | output | 1 | Incident bit of the current instruction |
| flops_o | output | 10 | State plane: bit 0 auxiliary, 1..8 ordering, 9 transfer |
| err_o | output | 1 | Last instruction had overlapping read and load groups |

## Verification
The hardest case to reach is a worst-case ordering pass, for example four ones packed above four zeros, run with the full step count. The state has no direct write path, so the bench first loads all ones and then clears the complement of the wanted pattern. Both loads run with the gates off, so the incident bit comes only from its inversion bit. The bubble is then issued with the same inversion, which gives an unconditional pass. Conditional and rhombic gating are reached by setting up chosen flop patterns in the same way before each gate test, and a long pseudo-random run covers the remaining combinations.

// File: rtl/grid_pe_pkg.sv
package grid_pe_pkg;
  localparam int NFLOP  = 10;
  localparam int NNBR   = 8;
  localparam int ITER_W = 3;

  // R1: layout, MSB first
  typedef struct packed {
    logic              cpl_out;
    logic              cpl_in;
    logic              gate_en;
    logic              bypass;
    logic              bub_en;
    logic              up;
    logic              down;
    logic [ITER_W-1:0] iters;
  } flow_t;

  typedef struct packed {
    flow_t            flow;
    logic [NFLOP-1:0] rd;
    logic [NFLOP-1:0] gate;
    logic [NFLOP-1:0] ld;
  } uinstr_t;
endpackage

// File: rtl/pe_transmit.sv
module pe_transmit #(
  parameter int N = 10
) (
  input  logic [N-1:0] st_i,
  input  logic [N-1:0] sel_i,
  input  logic         inv_i,
  output logic         out_o
);
  // unselected flops read as 1
  assign out_o = (&(st_i | ~sel_i)) ^ inv_i;
endmodule

// File: rtl/pe_receive.sv
module pe_receive #(
  parameter int NNBR = 8,
  parameter int DROP = 2
) (
  input  logic [NNBR:0]   st_i,
  input  logic            self_i,
  input  logic [NNBR-1:0] nbr_i,
  input  logic [NNBR:0]   gate_i,
  input  logic            cond_i,
  input  logic            en_i,
  input  logic            rhomb_i,
  input  logic            inv_i,
  output logic            inc_o
);
  localparam int KEEP = NNBR + 1 - DROP;

  logic [NNBR:0] src, mask, open;

  assign src  = {nbr_i, self_i};
  assign mask = rhomb_i ? {{DROP{1'b0}}, {KEEP{1'b1}}} : '1;

  always_comb begin
    open = '0;
    if (en_i) open = gate_i & mask & (cond_i ? st_i : '1);
  end

  assign inc_o = (|(open & src)) ^ inv_i;
endmodule

// File: rtl/pe_bubble.sv
module pe_bubble #(
  parameter int W        = 8,
  parameter int ITER_W   = 3,
  parameter int MAX_ITER = (1 << ITER_W) - 1
) (
  input  logic [W-1:0]      vec_i,
  input  logic              up_i,
  input  logic              down_i,
  input  logic [ITER_W-1:0] iters_i,
  output logic [W-1:0]      vec_o
);
  // index 0 is the top; one step moves each 1 above a 0 down by one
  function automatic logic [W-1:0] step_dn(input logic [W-1:0] v);
    logic [W-1:0] n;
    n[0]   = v[0] & v[1];
    n[W-1] = v[W-1] | v[W-2];
    for (int k = 1; k < W - 1; k++)
      n[k] = (v[k] & v[k+1]) | (~v[k] & v[k-1]);
    return n;
  endfunction

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = v[W-1-k];
    return r;
  endfunction

  logic         up_only, moving;
  logic [W-1:0] stg [MAX_ITER+1];
  logic [W-1:0] sel;

  assign up_only = up_i & ~down_i;
  assign moving  = up_i ^ down_i;
  assign stg[0]  = up_only ? rev(vec_i) : vec_i;

  for (genvar s = 0; s < MAX_ITER; s++) begin : g_stage
    assign stg[s+1] = step_dn(stg[s]);
  end

  assign sel   = stg[iters_i];
  assign vec_o = !moving ? vec_i : (up_only ? rev(sel) : sel);
endmodule

// File: rtl/grid_pe.sv
module grid_pe
  import grid_pe_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [39:0] instr_i,
  input  logic        rhombic_i,
  input  logic [7:0]  nbr_i,
  output logic        out_o,
  output logic        incident_o,
  output logic [9:0]  flops_o,
  output logic        err_o
);
  uinstr_t          ui;
  logic [NFLOP-1:0] st_q;
  logic [NNBR-1:0]  bub_vec;
  logic             conflict;

  assign ui = uinstr_t'(instr_i);

  pe_transmit #(.N(NFLOP)) u_tx (
    .st_i (st_q),
    .sel_i(ui.rd),
    .inv_i(ui.flow.cpl_out),
    .out_o(out_o)
  );

  // gate bit 9 is the conditional flag; gates 0..8 key to flops 0..8
  pe_receive #(.NNBR(NNBR), .DROP(2)) u_rx (
    .st_i   (st_q[NNBR:0]),
    .self_i (out_o),
    .nbr_i  (nbr_i),
    .gate_i (ui.gate[NNBR:0]),
    .cond_i (ui.gate[NFLOP-1]),
    .en_i   (ui.flow.gate_en),
    .rhomb_i(rhombic_i),
    .inv_i  (ui.flow.cpl_in),
    .inc_o  (incident_o)
  );

  pe_bubble #(.W(NNBR), .ITER_W(ITER_W)) u_bub (
    .vec_i  (st_q[NNBR:1]),
    .up_i   (ui.flow.up),
    .down_i (ui.flow.down),
    .iters_i(ui.flow.iters),
    .vec_o  (bub_vec)
  );

  assign conflict = |(ui.rd & ui.ld);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      err_o <= 1'b0;
    end else if (ui.flow.bub_en) begin
      err_o <= 1'b0;
      if (incident_o) st_q[NNBR:1] <= bub_vec;
    end else begin
      err_o <= conflict;
      if (!conflict) st_q <= (st_q & ~ui.ld) | ({NFLOP{incident_o}} & ui.ld);
    end
  end

  assign flops_o = st_q;
endmodule

// File: rtl/grid_pe_checker.sv
module grid_pe_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [39:0] instr_i,
  input logic        rhombic_i,
  input logic [7:0]  nbr_i,
  input logic        out_o,
  input logic        incident_o,
  input logic [9:0]  flops_o,
  input logic        err_o
);
  assert_empty_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[29:20] == 10'd0) |-> (out_o == !instr_i[39]));

  assert_gates_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_i[37] |-> (incident_o == instr_i[38]));

  assert_unloaded_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_i[35] |=> ((flops_o & ~$past(instr_i[9:0])) == ($past(flops_o) & ~$past(instr_i[9:0]))));

  assert_overlap_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_i[35] && |(instr_i[29:20] & instr_i[9:0])) |=> (err_o && $stable(flops_o)));

  assert_bubble_conserves_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[35] |=> (($countones(flops_o[8:1]) == $countones($past(flops_o[8:1])))
                     && (flops_o[0] == $past(flops_o[0])) && (flops_o[9] == $past(flops_o[9]))
                     && !err_o));

  assert_zero_steps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[35] && instr_i[32:30] == 3'd0) |=> $stable(flops_o));
endmodule

bind grid_pe grid_pe_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .instr_i   (instr_i),
  .rhombic_i (rhombic_i),
  .nbr_i     (nbr_i),
  .out_o     (out_o),
  .incident_o(incident_o),
  .flops_o   (flops_o),
  .err_o     (err_o)
);

// File: tb/grid_pe_tb_top.sv
module grid_pe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [39:0] instr;
  logic        rhomb;
  logic [7:0]  nbr;
  logic        out_o, incident_o, err_o;
  logic [9:0]  flops_o;

  always #5 clk = ~clk;

  grid_pe dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .rhombic_i(rhomb), .nbr_i(nbr),
    .out_o(out_o), .incident_o(incident_o), .flops_o(flops_o), .err_o(err_o)
  );

  typedef struct {
    logic [9:0] st;
    logic       err;
    string      req;
  } exp_t;

  exp_t       sb_q[$];
  int         checks = 0;
  int         fails  = 0;
  logic [9:0] m_st;

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] mk(input logic co, input logic ci, input logic ge,
                                     input logic bub, input logic up, input logic dn,
                                     input logic [2:0] n, input logic [9:0] rd,
                                     input logic [9:0] gt, input logic [9:0] ld);
    return {co, ci, ge, 1'b0, bub, up, dn, n, rd, gt, ld};
  endfunction

  function automatic logic m_out(input logic [9:0] s, input logic [39:0] ins);
    return (((s & ins[29:20]) == ins[29:20]) ? 1'b1 : 1'b0) ^ ins[39];
  endfunction

  function automatic logic m_inc(input logic [9:0] s, input logic [39:0] ins,
                                 input logic [7:0] nb, input logic rh);
    logic acc = 1'b0;
    for (int j = 0; j <= 8; j++) begin
      logic opn, src;
      opn = ins[37] && ins[10+j] && !(rh && j >= 7) && (!ins[19] || s[j]);
      src = (j == 0) ? m_out(s, ins) : nb[j-1];
      acc = acc | (opn & src);
    end
    return acc ^ ins[38];
  endfunction

  // v[0] is flop 1; scan with skip equals a simultaneous swap of disjoint pairs
  function automatic logic [7:0] mv(input logic [7:0] v, input logic dn);
    logic [7:0] r = v;
    int k = 0;
    while (k < 7) begin
      if ((dn && r[k] && !r[k+1]) || (!dn && !r[k] && r[k+1])) begin
        r[k] = ~r[k]; r[k+1] = ~r[k+1]; k += 2;
      end else k += 1;
    end
    return r;
  endfunction

  task automatic exec(input logic [39:0] ins, input logic [7:0] nb, input logic rh,
                      input string req);
    logic       o, i, cf, e;
    logic [9:0] nx;
    @(negedge clk);
    instr = ins; nbr = nb; rhomb = rh;
    #1;
    o = m_out(m_st, ins);
    i = m_inc(m_st, ins, nb, rh);
    chk({req, " out"}, {9'd0, out_o}, {9'd0, o});
    chk({req, " incident"}, {9'd0, incident_o}, {9'd0, i});
    nx = m_st;
    e  = 1'b0;
    if (ins[35]) begin
      if (i && (ins[33] != ins[34]))
        for (int s = 0; s < int'(ins[32:30]); s++) nx[8:1] = mv(nx[8:1], ins[33]);
    end else begin
      cf = |(ins[29:20] & ins[9:0]);
      e  = cf;
      if (!cf) for (int j = 0; j < 10; j++) if (ins[j]) nx[j] = i;
    end
    sb_q.push_back('{st: nx, err: e, req: req});
    m_st = nx;
  endtask

  // no direct write path: set all, then clear the complement
  task automatic set_pattern(input logic [9:0] p, input string req);
    exec(mk(0, 1, 0, 0, 0, 0, 3'd0, 10'd0, 10'd0, 10'h3FF), 8'h00, 1'b0, req);
    exec(mk(0, 0, 0, 0, 0, 0, 3'd0, 10'd0, 10'd0, ~p), 8'h00, 1'b0, req);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk({e.req, " state"}, flops_o, e.st);
      chk({e.req, " err"}, {9'd0, err_o}, {9'd0, e.err});
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; instr = '0; nbr = '0; rhomb = 1'b0; m_st = '0;
    repeat (3) @(negedge clk);
    chk("R10 flops", flops_o, 10'd0);
    chk("R10 err", {9'd0, err_o}, 10'd0);
    rst_n = 1'b1;

    // R2: empty read gives 1, inverted gives 0
    exec(40'd0, 8'h00, 1'b0, "R2");
    exec(mk(1, 0, 0, 0, 0, 0, 3'd0, 10'd0, 10'd0, 10'd0), 8'h00, 1'b0, "R2");
    // R6: load pattern and partial loads
    set_pattern(10'h2A5, "R6");
    exec(mk(0, 1, 0, 0, 0, 0, 3'd0, 10'd0, 10'd0, 10'h00A), 8'h00, 1'b0, "R6");
    // R2: AND over selected flops
    exec(mk(0, 0, 0, 0, 0, 0, 3'd0, 10'h205, 10'd0, 10'd0), 8'h00, 1'b0, "R2");
    exec(mk(0, 0, 0, 0, 0, 0, 3'd0, 10'h206, 10'd0, 10'd0), 8'h00, 1'b0, "R2");
    exec(mk(1, 0, 0, 0, 0, 0, 3'd0, 10'h206, 10'd0, 10'd0), 8'h00, 1'b0, "R2");
    // R3: neighbour gates, self gate, gates off
    exec(mk(0, 0, 1, 0, 0, 0, 3'd0, 10'd0, 10'h004, 10'd0), 8'h02, 1'b0, "R3");
    exec(mk(0, 0, 1, 0, 0, 0, 3'd0, 10'd0, 10'h004, 10'd0), 8'hFD, 1'b0, "R3");
    exec(mk(0, 0, 1, 0, 0, 0, 3'd0, 10'd0, 10'h001, 10'd0), 8'h00, 1'b0, "R3");
    exec(mk(0, 1, 1, 0, 0, 0, 3'd0, 10'd0, 10'h100, 10'd0), 8'h80, 1'b0, "R3");
    exec(mk(0, 0, 0, 0, 0, 0, 3'd0, 10'd0, 10'h1FF, 10'd0), 8'hFF, 1'b0, "R3");
    // R4: conditional gates keyed to flops
    set_pattern(10'h00C, "R4");
    exec(mk(0, 0, 1, 0, 0, 0, 3'd0, 10'd0, 10'h220, 10'd0), 8'hFF, 1'b0, "R4");
    exec(mk(0, 0, 1, 0, 0, 0, 3'd0, 10'd0, 10'h208, 10'h200), 8'h04, 1'b0, "R4");
    exec(mk(0, 0, 1, 0, 0, 0, 3'd0, 10'd0, 10'h208, 10'h001), 8'h00, 1'b0, "R4");
    // R5: rhombic drops gates 7 and 8
    exec(mk(0, 0, 1, 0, 0, 0, 3'd0, 10'd0, 10'h180, 10'h002), 8'hC0, 1'b1, "R5");
    exec(mk(0, 0, 1, 0, 0, 0, 3'd0, 10'd0, 10'h180, 10'h002), 8'hC0, 1'b0, "R5");
    exec(mk(0, 0, 1, 0, 0, 0, 3'd0, 10'd0, 10'h040, 10'd0), 8'h20, 1'b1, "R5");
    // R7: overlap suppresses load
    exec(mk(0, 1, 0, 0, 0, 0, 3'd0, 10'h003, 10'd0, 10'h3C2), 8'h00, 1'b0, "R7");
    exec(mk(0, 1, 0, 0, 0, 0, 3'd0, 10'h001, 10'd0, 10'h3C2), 8'h00, 1'b0, "R7");
    // R8: bubble directions, load ignored, incident gates the pass
    set_pattern(10'h20B, "R8");
    exec(mk(0, 1, 0, 1, 0, 1, 3'd2, 10'd0, 10'd0, 10'h3FF), 8'h00, 1'b0, "R8");
    exec(mk(0, 1, 0, 1, 1, 0, 3'd1, 10'd0, 10'd0, 10'd0), 8'h00, 1'b0, "R8");
    exec(mk(0, 0, 0, 1, 0, 1, 3'd5, 10'd0, 10'd0, 10'd0), 8'h00, 1'b0, "R8");
    exec(mk(0, 1, 0, 1, 1, 1, 3'd5, 10'd0, 10'd0, 10'd0), 8'h00, 1'b0, "R8");
    // R9: worst-case ordering in both directions, zero steps
    set_pattern(10'h01E, "R9");
    exec(mk(0, 1, 0, 1, 0, 1, 3'd7, 10'd0, 10'd0, 10'd0), 8'h00, 1'b0, "R9");
    @(posedge clk); #3;
    chk("R9 down", {2'b00, flops_o[8:1]}, 10'h0F0);
    exec(mk(0, 1, 0, 1, 1, 0, 3'd7, 10'd0, 10'd0, 10'd0), 8'h00, 1'b0, "R9");
    @(posedge clk); #3;
    chk("R9 up", {2'b00, flops_o[8:1]}, 10'h00F);
    exec(mk(0, 1, 0, 1, 0, 1, 3'd0, 10'd0, 10'd0, 10'd0), 8'h00, 1'b0, "R9");

    // R1: pseudo-random instructions over the full layout
    lfsr = 32'hACE1_1234;
    for (int t = 0; t < 400; t++) begin
      logic [39:0] ins;
      logic [7:0]  nb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ins[31:0] = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ins[39:32] = lfsr[7:0];
      nb = lfsr[15:8];
      if (lfsr[16]) ins[9:0] = ins[9:0] & ~ins[29:20];
      if (lfsr[17]) ins[29:20] = ins[29:20] & lfsr[27:18];
      exec(ins, nb, lfsr[28], "R1");
    end

    exec(40'd0, 8'h00, 1'b0, "R6");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule